// File: doc/BRIEF.md
# Write-Only Two-Wire Clock-Control Register Slave

This block is a receive-only slave on a two-wire serial bus (SCL/SDA). It fills a bank of byte-wide control registers that configure the clock outputs downstream. A fast system clock samples both bus lines. Each line passes through a synchronizer and a glitch filter, and the cleaned lines are decoded into START, STOP and SCL edge events. The slave answers only one fixed write address. It pulls SDA low for exactly one ACK clock after each byte it accepts and never drives SDA for any other reason.

A write transfer sends the address byte, then two bytes whose contents are discarded, then the data bytes. The two discarded bytes are a command code and a byte count, and both are acknowledged. Data bytes always land in register 0, 1, 2 and so on in order, because there is no subaddress. Once the bank is full, the slave stops acknowledging and stays quiet until the next START. An active-low power-down input silences the interface and leaves the register contents untouched. Only the true reset loads the register defaults.

The controller is one state machine with eight states:
- ST_IDLE waits for a START.
- ST_ADDR shifts in the address byte. A match moves to ST_ADDR_ACK. A mismatch, including the read address, moves to ST_IGNORE.
- ST_SKIP receives a discarded byte. ST_SKIP_ACK acknowledges it and then returns to ST_SKIP, or moves to ST_DATA after the second discarded byte.
- ST_DATA receives a data byte. If a register is free, the byte is written and the machine moves to ST_DATA_ACK, which returns to ST_DATA. If the bank is full, the machine moves to ST_IGNORE.

Every ACK state ends on the next SCL falling edge. In every state, START moves to ST_ADDR, STOP moves to ST_IDLE, and power-down forces ST_IDLE.

Top module: `clkctl_i2c_wr_slave`

## Requirements
- R1: After reset, the register bank reads as follows: register 0 = 0x0C, register 1 = 0xCF, register 2 = 0x7F, register 3 = 0xFF, register 5 = 0x37, and all other registers = 0x00.
- R2: START is a falling SDA while SCL is high. It begins address reception, and the byte that follows is compared as a whole against 0xD2 (7-bit address and a 0 R/W bit in the LSB).
- R3: Bytes are taken MSB first. The ACK (SDA pulled low) is asserted only after the SCL falling edge that ends the 8th bit, and it is held through the 9th SCL high phase.
- R4: The two bytes after the address are acknowledged and never written to any register.
- R5: Data bytes are written to register 0, then 1, then 2, and so on, and each one is acknowledged. Registers that receive no data byte keep their contents.
- R6: A byte with any other address, including the read address 0xD3, is not acknowledged, and the rest of that transfer changes no register.
- R7: At most 10 data bytes are accepted per transfer. The 11th and later bytes get no ACK and are not stored.
- R8: While the power-down input is low, the slave never pulls SDA and no register changes. The contents are kept after power-down is released.
- R9: A START in the middle of a byte discards the partial byte and restarts address reception.
- R10: An SDA pulse shorter than the filter length while SCL is high is ignored, so it is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low true power-up reset; loads the register defaults |
| pwr_dn_n | input | 1 | Active-low power-down; disables the bus interface |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK only) |
| regs_o | output | MAX_DATA*8 | Register bank; register k occupies bits [8k+7:8k] |

## Verification
The hardest cases to reach from the ports are the ones where the bus line changes while SCL is high but must not be taken as a bus condition, and the case where a real START cuts a byte in half. The stimulus breaks off an address byte after four bits and issues a repeated START, then checks that the following full transfer still lands in register 0. A second transfer injects an SDA dip two system clocks long in the middle of an SCL high phase of a data byte. That dip would read as a START if the filter were missing, and the check is that the transfer stays intact with every ACK present. Overflow past ten data bytes and a complete transfer under power-down are driven as well, with the whole register bank compared after each.

// File: rtl/clkctl_i2c_pkg.sv
package clkctl_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SKIP,
        ST_SKIP_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } slv_state_e;

    // Power-up content of each control register.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h0C;
            1:       return 8'hCF;
            2:       return 8'h7F;
            3:       return 8'hFF;
            5:       return 8'h37;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_line_filter.sv
module clkctl_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    // The output follows only after the synced level holds for FILT_LEN cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else if (synced == line_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            cnt_q  <= '0;
            line_o <= synced;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(synced) == line_o)); // R10

endmodule

// File: rtl/clkctl_bus_cond.sv
module clkctl_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_o    = scl_q && scl_f && sda_q && !sda_f;
    assign stop_o     = scl_q && scl_f && !sda_q && sda_f;
    assign scl_rise_o = !scl_q && scl_f;
    assign scl_fall_o = scl_q && !scl_f;

endmodule

// File: rtl/clkctl_wr_fsm.sv
module clkctl_wr_fsm
    import clkctl_i2c_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE  = 8'hD2,
    parameter int         SKIP_BYTES = 2,
    parameter int         MAX_DATA   = 10,
    localparam int        IW         = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic          stop,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_f,
    output logic          ack_o,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [7:0]    wr_data_o
);
    localparam int DCW = $clog2(MAX_DATA + 1);
    localparam int SCW = $clog2(SKIP_BYTES + 1);

    slv_state_e     state, nxt;
    logic [3:0]     bit_cnt;
    logic [7:0]     shift_q;
    logic [SCW-1:0] skip_cnt;
    logic [DCW-1:0] data_cnt;
    logic           byte_full, rx_state, room;

    assign byte_full = (bit_cnt == 4'd8);
    assign room      = (data_cnt < DCW'(MAX_DATA));
    assign rx_state  = (state == ST_ADDR) || (state == ST_SKIP) || (state == ST_DATA);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else if (start) begin
            nxt = ST_ADDR;
        end else if (stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR:
                    if (scl_fall && byte_full)
                        nxt = (shift_q == ADDR_BYTE) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:
                    if (scl_fall && byte_full) nxt = ST_SKIP_ACK;
                ST_SKIP_ACK:
                    if (scl_fall)
                        nxt = (skip_cnt == SCW'(SKIP_BYTES - 1)) ? ST_DATA : ST_SKIP;
                ST_DATA:
                    if (scl_fall && byte_full)
                        nxt = room ? ST_DATA_ACK : ST_IGNORE;
                ST_DATA_ACK:
                    if (scl_fall) nxt = ST_DATA;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Byte shifter and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            skip_cnt <= '0;
            data_cnt <= '0;
        end else if (!enable || start || stop) begin
            bit_cnt  <= '0;
            skip_cnt <= '0;
            data_cnt <= '0;
        end else begin
            if (scl_rise && rx_state && !byte_full) begin
                shift_q <= {shift_q[6:0], sda_f};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && ack_o) begin
                bit_cnt <= '0;
            end
            if (scl_fall && state == ST_SKIP_ACK) begin
                skip_cnt <= skip_cnt + 1'b1;
            end
            if (wr_en_o) begin
                data_cnt <= data_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ack_o     = (state == ST_ADDR_ACK) || (state == ST_SKIP_ACK) ||
                    (state == ST_DATA_ACK);
        wr_en_o   = (state == ST_DATA) && (nxt == ST_DATA_ACK);
        wr_idx_o  = data_cnt[IW-1:0];
        wr_data_o = shift_q;
    end

    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(scl_fall)); // R3
    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> ack_o); // R5
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ack_o && !wr_en_o)); // R8
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start) |=> (state == ST_ADDR && bit_cnt == 4'd0)); // R9

endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank
    import clkctl_i2c_pkg::*;
#(
    parameter int  NUM_REGS = 10,
    localparam int IW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          r_q <= reg_default(g);
            else if (wr_en && wr_idx == IW'(g))  r_q <= wr_data;
        end
        assign regs_o[g*8 +: 8] = r_q;
    end

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> $past(wr_en)); // R5

endmodule

// File: rtl/clkctl_i2c_wr_slave.sv
module clkctl_i2c_wr_slave #(
    parameter logic [7:0] ADDR_BYTE   = 8'hD2,
    parameter int         SKIP_BYTES  = 2,
    parameter int         MAX_DATA    = 10,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_dn_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [MAX_DATA*8-1:0] regs_o
);
    localparam int IW = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1;

    logic [1:0]    raw, filt;
    logic          start, stop, scl_rise, scl_fall, wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        clkctl_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw[g]),
            .line_o(filt[g])
        );
    end

    clkctl_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt[1]),
        .sda_f     (filt[0]),
        .start_o   (start),
        .stop_o    (stop),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    clkctl_wr_fsm #(
        .ADDR_BYTE (ADDR_BYTE),
        .SKIP_BYTES(SKIP_BYTES),
        .MAX_DATA  (MAX_DATA)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (pwr_dn_n),
        .start    (start),
        .stop     (stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_f    (filt[0]),
        .ack_o    (sda_pull_o),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .wr_data_o(wr_data)
    );

    clkctl_reg_bank #(
        .NUM_REGS(MAX_DATA)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .regs_o (regs_o)
    );

    AST_PD_REGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> $stable(regs_o)); // R8
    AST_PD_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> !sda_pull_o); // R8

endmodule

// File: tb/sim_clkctl_i2c_wr_slave.sv
module sim_clkctl_i2c_wr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // system clocks per quarter bus bit
    localparam int NREG       = 10;

    logic clk = 1'b0, rst_n = 1'b0, pwr_dn_n = 1'b1;
    logic scl = 1'b1, sda_tb = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    int checks = 0, errors = 0;
    logic [7:0] exp_regs [NREG];

    bit    exp_q [$];
    string tag_q [$];
    bit    ack_obs;
    event  ack_ev;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_tb & ~sda_pull;

    clkctl_i2c_wr_slave u0 (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
        .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .regs_o(regs)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each observed ACK slot with the queued expectation.
    initial begin
        forever begin
            @(ack_ev);
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%0d expected=none", !ack_obs);
            end else begin
                check(tag_q.pop_front(), {7'd0, !ack_obs}, {7'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_start();
        if (scl == 1'b0) begin
            wq(Q); sda_tb = 1'b1; wq(Q); scl = 1'b1; wq(2*Q);
        end
        sda_tb = 1'b0; wq(2*Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_tb = 1'b0; wq(Q); scl = 1'b1; wq(2*Q); sda_tb = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        wq(Q); sda_tb = b; wq(Q); scl = 1'b1;
        if (glitch) begin
            wq(Q - 1); sda_tb = ~b; wq(2); sda_tb = b; wq(Q - 1);
        end else begin
            wq(2*Q);
        end
        scl = 1'b0;
    endtask

    // Driver: pushes the expected ACK into the scoreboard, then clocks the byte out.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag,
                             input int glitch_bit = -1);
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i], (i == glitch_bit));
        wq(Q); sda_tb = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        ack_obs = sda_line; -> ack_ev;
        wq(Q); scl = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) check(tag, regs[i*8 +: 8], exp_regs[i]);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        exp_regs[0] = 8'h0C; exp_regs[1] = 8'hCF; exp_regs[2] = 8'h7F;
        exp_regs[3] = 8'hFF; exp_regs[5] = 8'h37;
        wq(5); rst_n = 1'b1; wq(5);

        // R1 reset contents
        check_regs("R1");
        check("R1 sda released", {7'd0, sda_pull}, 8'h00);

        // R2 R3 R4 R5: address, two discarded bytes, three data bytes
        bus_start();
        send_byte(8'hD2, 1'b1, "R2 addr ack");
        send_byte(8'hA5, 1'b1, "R4 cmd ack");
        send_byte(8'h5A, 1'b1, "R4 count ack");
        send_byte(8'h81, 1'b1, "R3 data0 ack"); exp_regs[0] = 8'h81;
        send_byte(8'h42, 1'b1, "R5 data1 ack"); exp_regs[1] = 8'h42;
        send_byte(8'h3C, 1'b1, "R5 data2 ack"); exp_regs[2] = 8'h3C;
        bus_stop();
        check_regs("R5 R4 sequential fill");

        // R6 wrong address and read address
        bus_start();
        send_byte(8'hD0, 1'b0, "R6 other addr no ack");
        send_byte(8'h11, 1'b0, "R6 silent");
        send_byte(8'h22, 1'b0, "R6 silent");
        send_byte(8'h33, 1'b0, "R6 silent");
        bus_stop();
        bus_start();
        send_byte(8'hD3, 1'b0, "R6 read addr no ack");
        send_byte(8'h44, 1'b0, "R6 silent");
        bus_stop();
        check_regs("R6 unchanged");

        // R7 overflow: 12 data bytes, only 10 accepted
        bus_start();
        send_byte(8'hD2, 1'b1, "R7 addr");
        send_byte(8'h00, 1'b1, "R7 cmd");
        send_byte(8'h00, 1'b1, "R7 count");
        for (int i = 0; i < 10; i++) begin
            send_byte(8'h10 + 8'(i), 1'b1, "R7 data ack");
            exp_regs[i] = 8'h10 + 8'(i);
        end
        send_byte(8'hEE, 1'b0, "R7 11th no ack");
        send_byte(8'hDD, 1'b0, "R7 12th no ack");
        bus_stop();
        check_regs("R7 bank");

        // R8 power-down: full transfer ignored
        pwr_dn_n = 1'b0;
        bus_start();
        send_byte(8'hD2, 1'b0, "R8 pd addr");
        send_byte(8'h00, 1'b0, "R8 pd cmd");
        send_byte(8'h00, 1'b0, "R8 pd count");
        send_byte(8'h99, 1'b0, "R8 pd data");
        bus_stop();
        check_regs("R8 during pd");
        pwr_dn_n = 1'b1; wq(4);
        check_regs("R8 after pd");

        // R9 START in the middle of a byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        bus_start();
        send_byte(8'hD2, 1'b1, "R9 addr after restart");
        send_byte(8'h01, 1'b1, "R9 cmd");
        send_byte(8'h02, 1'b1, "R9 count");
        send_byte(8'h6B, 1'b1, "R9 data0"); exp_regs[0] = 8'h6B;
        bus_stop();
        check_regs("R9 bank");

        // R10 glitch on SDA while SCL is high
        bus_start();
        send_byte(8'hD2, 1'b1, "R10 addr");
        send_byte(8'h00, 1'b1, "R10 cmd");
        send_byte(8'h00, 1'b1, "R10 count");
        send_byte(8'hF0, 1'b1, "R10 glitch data0", 5); exp_regs[0] = 8'hF0;
        send_byte(8'h0F, 1'b1, "R10 glitch data1", 2); exp_regs[1] = 8'h0F;
        bus_stop();
        check_regs("R10 bank");

        wq(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule